// File: doc/BRIEF.md
# Register-Triggered Flash Port Controller

This block bridges a simple host register interface to a byte-wide flash device on an external expansion bus. The host sets a control register, a 16-bit lower address and an 8-bit upper address byte. It then touches the data port register, and that access is itself the command. A read of the data port runs a flash read cycle, and the returned byte lands in the data port register when the cycle ends. A write of the data port runs a flash write cycle, but only while the flash enable bit is set.

Every bus cycle holds chip select and one strobe, output enable for a read or write enable for a write, active for a programmable count of 1 to 16 clocks. A busy flag covers the whole cycle, and data port accesses made while it is set are dropped. The upper address byte is write-protected unless the device reports that it is halted or that no SRAM is configured. A soft reset aborts any cycle and clears the control register. It leaves the address and data registers as they are.

Top module: `flash_port_ctrl`

## Requirements
- R1: A host read (host_sel=1, host_rd=1, host_wr=0) of register 3 while idle starts a read cycle with eb_cs_n=0, eb_oe_n=0 and eb_we_n=1. At the edge that ends the cycle, eb_din is stored into the data port, which reads back on host_rdata[7:0] when host_addr=3.
- R2: A host write of register 3 while idle always loads host_wdata[7:0] into the data port. It starts a write cycle only when control bit 0 (flash enable) is 1, and during that cycle eb_cs_n=0, eb_we_n=0, eb_oe_n=1, eb_dout_en=1 and eb_dout equals the data port.
- R3: Register 1 (upper address byte, bits 7:0) takes a write only in a cycle where halted=1 or sram_cfg=0. Any other write leaves it unchanged.
- R4: Register 0 reads flash enable on bit 0, auto-increment on bit 1, wait count minus one on bits 7:4 and busy on bit 8. Every unused bit of every register reads 0.
- R5: With bits 7:4 of register 0 equal to W, the strobes of a cycle stay active for exactly W+1 clock cycles.
- R6: busy is 1 from the edge that starts a cycle until the edge that releases the strobes. Data port reads and writes made while busy start nothing and change nothing.
- R7: Register 2 holds the 16-bit lower address. When control bit 1 is 1, it increments by one, wrapping from FFFFh to 0000h, at the edge that completes a cycle. A host write to register 2 on that same edge takes priority over the increment.
- R8: eb_addr carries {upper byte, lower address} as captured at cycle start and holds that value until the cycle ends.
- R9: A one-cycle soft_rst pulse ends any cycle without capturing data or incrementing the address, and clears register 0. The upper byte, lower address and data port keep their values.
- R10: While rst_n is low, eb_cs_n, eb_oe_n and eb_we_n are 1, busy is 0, and registers 0 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset |
| host_sel | input | 1 | Host access select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the indexed register |
| halted | input | 1 | Device halted status |
| sram_cfg | input | 8 | Configured SRAM size; zero means none |
| busy | output | 1 | Bus cycle in progress |
| eb_addr | output | 24 | Expansion bus address |
| eb_dout | output | 8 | Expansion bus write data |
| eb_dout_en | output | 1 | Drive enable for eb_dout |
| eb_din | input | 8 | Expansion bus read data |
| eb_cs_n | output | 1 | Chip select, active low |
| eb_oe_n | output | 1 | Output enable, active low |
| eb_we_n | output | 1 | Write enable, active low |

## Verification
The embedded assertions check the following on every cycle:
- An accepted data port access turns busy on at the next edge.
- A disabled flash write never raises busy.
- The bus address stays stable for the length of a cycle.
- A write to the data port while busy leaves it untouched.
- The upper byte never moves while the protect condition holds.
- busy falls after completion.

Only the bench's scenarios can show these:
- The exact strobe length for each wait count.
- The captured read byte.
- Address wrap under auto-increment.
- The write-versus-increment priority.
- What a soft reset keeps and what it drops.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // Register indices seen on host_addr
  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_UPPER = 2'd1;
  localparam logic [1:0] REG_LOWER = 2'd2;
  localparam logic [1:0] REG_DATA  = 2'd3;

  // Wait field covers 1..16 strobe cycles
  localparam int WAIT_W = 4;

  // Control register bit positions
  localparam int CTRL_FEN_BIT  = 0;
  localparam int CTRL_AINC_BIT = 1;
  localparam int CTRL_WAIT_LSB = 4;
  localparam int CTRL_BUSY_BIT = CTRL_WAIT_LSB + WAIT_W;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ACT = 1'b1} seq_state_e;
endpackage

// File: rtl/fpc_regs.sv
module fpc_regs
  import fpc_pkg::*;
#(
  parameter int HW    = 32,
  parameter int DW    = 8,
  parameter int UP_W  = 8,
  parameter int LO_W  = 16,
  parameter int SZ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [HW-1:0]     host_wdata,
  output logic [HW-1:0]     host_rdata,
  input  logic              halted,
  input  logic [SZ_W-1:0]   sram_cfg,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic [DW-1:0]     rd_byte_i,
  output logic              start_o,
  output logic              start_wr_o,
  output logic [WAIT_W-1:0] wait_m1_o,
  output logic [UP_W-1:0]   upper_o,
  output logic [LO_W-1:0]   lower_o,
  output logic [DW-1:0]     data_o
);
  logic              fen_q, fen_d, ainc_q, ainc_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              ctrl_en;
  logic [UP_W-1:0]   upper_q;
  logic              up_we;
  logic [LO_W-1:0]   lower_q, lower_d;
  logic              lower_en;
  logic [DW-1:0]     data_q, data_d;
  logic              data_en;
  logic              wr_ctrl, wr_upper, wr_lower, wr_data, rd_data;
  logic              unused_wdata;

  assign unused_wdata = ^host_wdata[HW-1:LO_W];

  // Host access decode
  assign wr_ctrl  = host_sel & host_wr & (host_addr == REG_CTRL);
  assign wr_upper = host_sel & host_wr & (host_addr == REG_UPPER);
  assign wr_lower = host_sel & host_wr & (host_addr == REG_LOWER);
  assign wr_data  = host_sel & host_wr & (host_addr == REG_DATA) & ~busy_i;
  assign rd_data  = host_sel & host_rd & ~host_wr & (host_addr == REG_DATA) & ~busy_i;

  assign start_wr_o = wr_data & fen_q;
  assign start_o    = rd_data | start_wr_o;

  // Control register: next state
  always_comb begin
    ctrl_en = 1'b0;
    fen_d   = fen_q;
    ainc_d  = ainc_q;
    wait_d  = wait_q;
    if (soft_rst) begin
      ctrl_en = 1'b1;
      fen_d   = 1'b0;
      ainc_d  = 1'b0;
      wait_d  = '0;
    end else if (wr_ctrl) begin
      ctrl_en = 1'b1;
      fen_d   = host_wdata[CTRL_FEN_BIT];
      ainc_d  = host_wdata[CTRL_AINC_BIT];
      wait_d  = host_wdata[CTRL_WAIT_LSB +: WAIT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q  <= 1'b0;
      ainc_q <= 1'b0;
      wait_q <= '0;
    end else if (ctrl_en) begin
      fen_q  <= fen_d;
      ainc_q <= ainc_d;
      wait_q <= wait_d;
    end
  end

  // Upper byte: write-protected, no reset
  assign up_we = wr_upper & (halted | (sram_cfg == '0));

  always_ff @(posedge clk) begin
    if (up_we) upper_q <= host_wdata[UP_W-1:0];
  end

  // Lower address: host write beats auto-increment
  always_comb begin
    lower_en = 1'b0;
    lower_d  = lower_q;
    if (wr_lower) begin
      lower_en = 1'b1;
      lower_d  = host_wdata[LO_W-1:0];
    end else if (done_i && ainc_q) begin
      lower_en = 1'b1;
      lower_d  = lower_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lower_q <= '0;
    else if (lower_en) lower_q <= lower_d;
  end

  // Data port: host write while idle, or captured read byte
  always_comb begin
    data_en = 1'b0;
    data_d  = data_q;
    if (wr_data) begin
      data_en = 1'b1;
      data_d  = host_wdata[DW-1:0];
    end else if (done_rd_i) begin
      data_en = 1'b1;
      data_d  = rd_byte_i;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
  end

  // Read mux, unused bits zero
  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      REG_CTRL: begin
        host_rdata[CTRL_FEN_BIT]               = fen_q;
        host_rdata[CTRL_AINC_BIT]              = ainc_q;
        host_rdata[CTRL_WAIT_LSB +: WAIT_W]    = wait_q;
        host_rdata[CTRL_BUSY_BIT]              = busy_i;
      end
      REG_UPPER: host_rdata[UP_W-1:0] = upper_q;
      REG_LOWER: host_rdata[LO_W-1:0] = lower_q;
      default:   host_rdata[DW-1:0]   = data_q;
    endcase
  end

  assign wait_m1_o = wait_q;
  assign upper_o   = upper_q;
  assign lower_o   = lower_q;
  assign data_o    = data_q;

  // R3
  upper_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && sram_cfg != '0) |=> $stable(upper_q));

  // R2
  no_write_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_addr == REG_DATA && !fen_q && !busy_i && !soft_rst) |=> !busy_i);

  // R6
  data_hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !done_rd_i && host_sel && host_wr && host_addr == REG_DATA) |=> $stable(data_q));
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              start_i,
  input  logic              start_wr_i,
  input  logic [WAIT_W-1:0] wait_m1_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rd_o,
  output logic              is_wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_n_o,
  output logic              oe_n_o,
  output logic              we_n_o
);
  seq_state_e        state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    if (soft_rst) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_d = SEQ_ACT;
          cnt_d   = wait_m1_i;
          wr_d    = start_wr_i;
          addr_d  = addr_i;
        end
        default: begin
          if (cnt_q == '0) state_d = SEQ_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
    end
  end

  assign busy_o    = (state_q == SEQ_ACT);
  assign done_o    = busy_o & (cnt_q == '0) & ~soft_rst;
  assign done_rd_o = done_o & ~wr_q;
  assign is_wr_o   = wr_q;
  assign addr_o    = addr_q;
  assign cs_n_o    = ~busy_o;
  assign oe_n_o    = ~(busy_o & ~wr_q);
  assign we_n_o    = ~(busy_o & wr_q);

  // R6
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !soft_rst) |=> busy_o);

  // R6
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && !soft_rst) |=> $stable(addr_o));
endmodule

// File: rtl/flash_port_ctrl.sv
module flash_port_ctrl
  import fpc_pkg::*;
#(
  parameter int HW   = 32,
  parameter int DW   = 8,
  parameter int UP_W = 8,
  parameter int LO_W = 16,
  parameter int SZ_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 host_sel,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [1:0]           host_addr,
  input  logic [HW-1:0]        host_wdata,
  output logic [HW-1:0]        host_rdata,
  input  logic                 halted,
  input  logic [SZ_W-1:0]      sram_cfg,
  output logic                 busy,
  output logic [UP_W+LO_W-1:0] eb_addr,
  output logic [DW-1:0]        eb_dout,
  output logic                 eb_dout_en,
  input  logic [DW-1:0]        eb_din,
  output logic                 eb_cs_n,
  output logic                 eb_oe_n,
  output logic                 eb_we_n
);
  localparam int ADDR_W = UP_W + LO_W;

  logic              start, start_wr, done, done_rd, is_wr;
  logic [WAIT_W-1:0] wait_m1;
  logic [UP_W-1:0]   upper;
  logic [LO_W-1:0]   lower;
  logic [DW-1:0]     data;

  fpc_regs #(.HW(HW), .DW(DW), .UP_W(UP_W), .LO_W(LO_W), .SZ_W(SZ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .halted(halted), .sram_cfg(sram_cfg),
    .busy_i(busy), .done_i(done), .done_rd_i(done_rd), .rd_byte_i(eb_din),
    .start_o(start), .start_wr_o(start_wr), .wait_m1_o(wait_m1),
    .upper_o(upper), .lower_o(lower), .data_o(data)
  );

  fpc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .start_i(start), .start_wr_i(start_wr), .wait_m1_i(wait_m1),
    .addr_i({upper, lower}),
    .busy_o(busy), .done_o(done), .done_rd_o(done_rd), .is_wr_o(is_wr),
    .addr_o(eb_addr), .cs_n_o(eb_cs_n), .oe_n_o(eb_oe_n), .we_n_o(eb_we_n)
  );

  assign eb_dout    = data;
  assign eb_dout_en = busy & is_wr;
endmodule

// File: tb/flash_port_ctrl_bench.sv
module flash_port_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, host_sel, host_wr, host_rd;
  logic [1:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        halted;
  logic [7:0]  sram_cfg;
  logic        busy, eb_dout_en, eb_cs_n, eb_oe_n, eb_we_n;
  logic [23:0] eb_addr;
  logic [7:0]  eb_dout, eb_din;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  flash_port_ctrl u_flash_port_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .halted(halted), .sram_cfg(sram_cfg), .busy(busy),
    .eb_addr(eb_addr), .eb_dout(eb_dout), .eb_dout_en(eb_dout_en), .eb_din(eb_din),
    .eb_cs_n(eb_cs_n), .eb_oe_n(eb_oe_n), .eb_we_n(eb_we_n)
  );

  function automatic logic [7:0] flash_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign eb_din = eb_cs_n ? 8'h00 : flash_byte(eb_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_busy, m_wr, m_fen, m_ainc, m_up_ok, m_dat_ok;
  int          m_cnt, m_wait;
  logic [23:0] m_addr;
  logic [7:0]  m_up, m_dat;
  logic [15:0] m_lo;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_fen = 0; m_ainc = 0; m_wait = 0; m_lo = 0; m_cnt = 0;
    end else if (soft_rst) begin
      m_busy = 0; m_fen = 0; m_ainc = 0; m_wait = 0;
    end else begin
      bit p_busy, p_fen, p_ainc, wlo, st, st_wr;
      int p_wait;
      logic [7:0]  p_up;
      logic [15:0] p_lo;
      p_busy = m_busy; p_fen = m_fen; p_ainc = m_ainc; p_wait = m_wait;
      p_up = m_up; p_lo = m_lo;
      wlo = host_sel && host_wr && host_addr == 2;
      st = 0; st_wr = 0;
      if (p_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          if (!m_wr) begin m_dat = flash_byte(m_addr); m_dat_ok = 1; end
          if (p_ainc && !wlo) m_lo = p_lo + 16'd1;
        end else m_cnt--;
      end
      if (host_sel && host_wr) begin
        case (host_addr)
          2'd0: begin m_fen = host_wdata[0]; m_ainc = host_wdata[1]; m_wait = int'(host_wdata[7:4]); end
          2'd1: if (halted || sram_cfg == 0) begin m_up = host_wdata[7:0]; m_up_ok = 1; end
          2'd2: m_lo = host_wdata[15:0];
          default: if (!p_busy) begin
            m_dat = host_wdata[7:0]; m_dat_ok = 1;
            if (p_fen) begin st = 1; st_wr = 1; end
          end
        endcase
      end else if (host_sel && host_rd && host_addr == 3 && !p_busy) st = 1;
      if (st) begin
        m_busy = 1; m_wr = st_wr; m_cnt = p_wait; m_addr = {p_up, p_lo};
      end
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(busy == m_busy, "R6 busy", 32'(busy), 32'(m_busy));
      chk(eb_cs_n == !m_busy, "R5 cs_n", 32'(eb_cs_n), 32'(!m_busy));
      chk(eb_oe_n == !(m_busy && !m_wr), "R1 oe_n", 32'(eb_oe_n), 32'(!(m_busy && !m_wr)));
      chk(eb_we_n == !(m_busy && m_wr), "R2 we_n", 32'(eb_we_n), 32'(!(m_busy && m_wr)));
      chk(eb_dout_en == (m_busy && m_wr), "R2 dout_en", 32'(eb_dout_en), 32'(m_busy && m_wr));
      if (m_busy && m_up_ok) chk(eb_addr == m_addr, "R8 eb_addr", 32'(eb_addr), 32'(m_addr));
      if (m_busy && m_wr && m_dat_ok) chk(eb_dout == m_dat, "R2 eb_dout", 32'(eb_dout), 32'(m_dat));
      case (host_addr)
        2'd0: begin
          logic [31:0] e;
          e = 32'(m_fen) | (32'(m_ainc) << 1) | (32'(m_wait) << 4) | (32'(m_busy) << 8);
          chk(host_rdata == e, "R4 ctrl read", host_rdata, e);
        end
        2'd1: if (m_up_ok) chk(host_rdata == 32'(m_up), "R3 upper read", host_rdata, 32'(m_up));
        2'd2: chk(host_rdata == 32'(m_lo), "R7 lower read", host_rdata, 32'(m_lo));
        default: if (m_dat_ok) chk(host_rdata == 32'(m_dat), "R1 data read", host_rdata, 32'(m_dat));
      endcase
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      host_sel = 0; host_wr = 0; host_rd = 0; host_addr = 2'(i % 4);
      step();
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    host_sel = 1; host_wr = 1; host_rd = 0; host_addr = a; host_wdata = d;
    step();
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hread(input logic [1:0] a);
    host_sel = 1; host_wr = 0; host_rd = 1; host_addr = a;
    step();
    host_sel = 0; host_rd = 0;
  endtask

  task automatic hard_reset_checks();
    rst_n = 0; host_sel = 0; host_wr = 0; host_rd = 0;
    m_up_ok = 0; m_dat_ok = 0;
    step(); step();
    host_addr = 0; #1;
    chk(eb_cs_n && eb_oe_n && eb_we_n, "R10 strobes idle", {29'd0, eb_cs_n, eb_oe_n, eb_we_n}, 32'h7);
    chk(!busy, "R10 busy low", 32'(busy), 32'h0);
    chk(host_rdata == 0, "R10 ctrl zero", host_rdata, 32'h0);
    host_addr = 2; #1;
    chk(host_rdata == 0, "R10 lower zero", host_rdata, 32'h0);
    step();
    rst_n = 1;
    step();
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    soft_rst = 0; halted = 0; sram_cfg = 8'h10;
    host_sel = 0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    hard_reset_checks();

    // R3: protect gating of the upper byte
    halted = 1; hwrite(1, 32'h3C); halted = 0;
    hwrite(1, 32'h77); idle(4);
    host_addr = 1; #1;
    chk(host_rdata == 32'h3C, "R3 write ignored", host_rdata, 32'h3C);
    sram_cfg = 0; hwrite(1, 32'h12); sram_cfg = 8'h10; idle(4);
    host_addr = 1; #1;
    chk(host_rdata == 32'h12, "R3 write accepted", host_rdata, 32'h12);

    // R2: data write with flash disabled runs no cycle
    hwrite(3, 32'h99);
    chk(!busy && eb_cs_n, "R2 no cycle when disabled", 32'(busy), 32'h0);
    idle(4);

    // R1/R5: single-cycle read
    hwrite(0, 32'h01); hwrite(2, 32'h1234);
    hread(3); idle(4);
    host_addr = 3; #1;
    chk(host_rdata == 32'(flash_byte(24'h121234)), "R1 captured byte", host_rdata, 32'(flash_byte(24'h121234)));

    // R5/R6/R7: long write with auto-increment, accesses while busy dropped
    hwrite(0, 32'hF3);
    hwrite(3, 32'h5E);
    idle(3);
    hwrite(3, 32'hFF); hread(3); idle(20);
    host_addr = 2; #1;
    chk(host_rdata == 32'h1235, "R7 increment", host_rdata, 32'h1235);

    // R7: wrap from FFFF
    hwrite(0, 32'h33); hwrite(2, 32'hFFFF); hread(3); idle(8);
    host_addr = 2; #1;
    chk(host_rdata == 32'h0000, "R7 wrap", host_rdata, 32'h0);

    // R7: host write wins on completion edge (wait count 1)
    hwrite(0, 32'h03); hread(3); hwrite(2, 32'h0400); idle(4);
    host_addr = 2; #1;
    chk(host_rdata == 32'h0400, "R7 write priority", host_rdata, 32'h400);

    // R9: soft reset aborts a cycle
    hwrite(0, 32'h73); hwrite(3, 32'h00); hwrite(0, 32'h72);
    hread(3); idle(3);
    soft_rst = 1; step(); soft_rst = 0;
    chk(!busy && eb_cs_n, "R9 cycle aborted", 32'(busy), 32'h0);
    host_addr = 0; #1;
    chk(host_rdata == 0, "R9 ctrl cleared", host_rdata, 32'h0);
    host_addr = 3; #1;
    chk(host_rdata == 32'h00, "R9 data kept", host_rdata, 32'h0);
    host_addr = 2; #1;
    chk(host_rdata == 32'h0400, "R9 lower kept", host_rdata, 32'h400);
    host_addr = 1; #1;
    chk(host_rdata == 32'h12, "R9 upper kept", host_rdata, 32'h12);
    idle(8);

    hard_reset_checks();
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule